// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five software localities (0 to 4) owns a shared security-device register interface at any moment. Every bus access carries an address, and the locality is taken from a fixed field of that address, so each locality sees its own 4 KB window. At offset 0 of each window sits a one-byte ownership register. Writes to it request the interface, release it, seize it from a lower-numbered owner, or acknowledge that ownership was taken away.

Ownership moves in one of two ways. If nothing has to be stopped, the move happens at once. Otherwise the block first asks the command engine to abort the running command, and the new owner takes over only when the engine reports that the abort is done. The block drives the current owner, a one-cycle pulse when a new owner is installed, and the abort request. Locality 4 only accepts writes that are flagged as coming from hardware.

Top module: `loc_arbiter`

## Requirements
- R1: The locality is addr_i[14:12] and the ownership register is at window offset 0. Other offsets in windows 0 to 4 read 8'h00. Windows 5 to 7 read 8'hFF, and writes to them have no effect.
- R2: Ownership register read layout: bit7 = 1, bit6 = 0, bit5 = this locality owns, bit4 = seized flag, bit3 = 0 (the stored seize request is never shown), bit2 = some other locality has a pending request, bit1 = own pending request, bit0 = parameter EST_VAL (default 1). After reset every locality reads 8'h81, active_o is 3'b111 (no owner) and abort_req_o is 0.
- R3: A write with bit1 set while no locality owns and no abort is outstanding makes the writer the owner on the next cycle, with loc_changed_o high for exactly that one cycle.
- R4: A write with bit1 set from a non-owner while another locality owns sets the writer's pending request. The other localities then read bit2 = 1.
- R5: When the owner writes bit5 while some locality has a pending request, abort_req_o rises and the owner is unchanged. On abort_done_i the owner becomes the highest-numbered requester, whose request is cleared. The old owner loses both ownership and its request, and loc_changed_o pulses.
- R6: When the owner writes bit5 and no request is pending, the interface goes unowned at once. There is no abort and no loc_changed_o pulse.
- R7: When a non-owner writes bit5, only its own pending request is cleared.
- R8: A write with bit3 set is accepted when no locality owns, or when the writer's number is higher than the owner's. Bits 5 and 1 in the same write are ignored. An accepted seize raises abort_req_o, and on abort_done_i the seizer becomes the owner and the previous owner gets its seized flag set.
- R9: A seize from a locality numbered at or below the owner's is ignored. So is a seize while a seize from the same or a higher locality is still stored. At most one stored seize exists at a time.
- R10: Writing bit4 = 1 clears the writer's seized flag.
- R11: Writes to locality 4 are dropped unless hw_i is 1. Reads of locality 4 are always allowed.
- R12: While an abort is outstanding, seize writes and owner releases are ignored. A request write only sets the pending request and never grants ownership directly.
- R13: abort_req_o stays high until abort_done_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| acc_valid_i | input | 1 | bus access strobe |
| acc_we_i | input | 1 | 1 = write |
| acc_addr_i | input | 15 | access address |
| acc_wdata_i | input | 8 | write data |
| acc_hw_i | input | 1 | access comes from hardware |
| acc_rdata_o | output | 8 | read data for acc_addr_i, combinational |
| active_o | output | 3 | current owner, 3'b111 = none |
| loc_changed_o | output | 1 | one-cycle pulse when a new owner is installed |
| abort_req_o | output | 1 | abort request to the command engine |
| abort_done_i | input | 1 | abort completed by the command engine |

## Verification
The bench uses the default build: five localities, 12 window address bits and EST_VAL = 1. This is small enough to sweep every ordered pair of owner and contender. The pairs cover request then release handover, seize in both directions, the no-owner and hardware-only cases for locality 4, and the window while an abort is held. Expected register bytes are built from the bit layout in R2.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int LOC_W = 3;
  typedef logic [LOC_W-1:0] loc_t;
  localparam loc_t NO_LOC = 3'b111;
  localparam int B_VALID  = 7;
  localparam int B_ACTIVE = 5;
  localparam int B_SEIZED = 4;
  localparam int B_SEIZE  = 3;
  localparam int B_PEND   = 2;
  localparam int B_REQ    = 1;
endpackage

// File: rtl/loc_addr_decode.sv
module loc_addr_decode
  import loc_arb_pkg::*;
#(
  parameter int N         = 5,
  parameter int LOC_SHIFT = 12,
  localparam int AW       = LOC_SHIFT + LOC_W
) (
  input  logic [AW-1:0] addr_i,
  output loc_t          loc_o,
  output logic          reg_hit_o,
  output logic          loc_valid_o
);
  assign loc_o       = addr_i[LOC_SHIFT +: LOC_W];
  assign reg_hit_o   = (addr_i[LOC_SHIFT-1:0] == '0);
  assign loc_valid_o = (int'(loc_o) < N);
endmodule

// File: rtl/loc_prio_scan.sv
module loc_prio_scan
  import loc_arb_pkg::*;
#(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output loc_t         hi_o,
  output logic         any_o,
  output logic [N-1:0] others_o
);
  always_comb begin
    hi_o = NO_LOC;
    for (int l = 0; l < N; l++)
      if (req_i[l]) hi_o = loc_t'(l);
  end
  assign any_o = |req_i;

  for (genvar g = 0; g < N; g++) begin : g_oth
    logic [N-1:0] mask;
    assign mask        = ~(N'(1) << g);
    assign others_o[g] = |(req_i & mask);
  end
endmodule

// File: rtl/loc_owner_fsm.sv
module loc_owner_fsm
  import loc_arb_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  loc_t         loc_i,
  input  logic         w_rel_i,
  input  logic         w_seize_i,
  input  logic         w_req_i,
  input  logic         w_clr_seized_i,
  input  logic         abort_done_i,
  input  loc_t         hi_req_i,
  input  logic         any_req_i,
  output logic [N-1:0] req_o,
  output logic [N-1:0] seized_o,
  output loc_t         active_o,
  output logic         changed_o,
  output logic         pend_o
);
  logic [N-1:0] req_q, req_d, seize_q, seize_d, seized_q, seized_d;
  loc_t act_q, act_d, nxt_q, nxt_d;
  logic pend_q, pend_d, chg_q, chg_d;

  logic do_chg, is_seize, act_valid, owner, blk;
  loc_t chg_to;

  assign act_valid = (act_q != NO_LOC);
  assign owner     = (act_q == loc_i);

  always_comb begin
    req_d = req_q; seize_d = seize_q; seized_d = seized_q;
    act_d = act_q; nxt_d = nxt_q; pend_d = pend_q; chg_d = 1'b0;
    do_chg = 1'b0; chg_to = NO_LOC; is_seize = 1'b0; blk = 1'b0;
    for (int l = 0; l < N; l++)
      if (seize_q[l] && (loc_t'(l) >= loc_i)) blk = 1'b1;
    if (wr_i) begin
      for (int l = 0; l < N; l++)
        if (w_clr_seized_i && loc_t'(l) == loc_i) seized_d[l] = 1'b0;
      if (w_seize_i) begin
        if (!pend_q && (!act_valid || loc_i > act_q) && !blk) begin
          for (int l = 0; l < N; l++) begin
            if (loc_t'(l) < loc_i) seize_d[l] = 1'b0;
            if (loc_t'(l) == loc_i) seize_d[l] = 1'b1;
          end
          pend_d = 1'b1;
          nxt_d  = loc_i;
        end
      end else begin
        if (w_rel_i) begin
          if (owner) begin
            if (!pend_q) begin
              if (any_req_i) begin
                pend_d = 1'b1;
                nxt_d  = hi_req_i;
              end else begin
                do_chg = 1'b1;
                chg_to = NO_LOC;
              end
            end
          end else begin
            for (int l = 0; l < N; l++)
              if (loc_t'(l) == loc_i) req_d[l] = 1'b0;
          end
        end
        if (w_req_i && !owner) begin
          if (act_valid || pend_q) begin
            for (int l = 0; l < N; l++)
              if (loc_t'(l) == loc_i) req_d[l] = 1'b1;
          end else begin
            do_chg = 1'b1;
            chg_to = loc_i;
          end
        end
      end
    end
    if (abort_done_i && pend_q) begin
      do_chg = 1'b1;
      chg_to = nxt_q;
      pend_d = 1'b0;
      nxt_d  = NO_LOC;
    end
    if (do_chg) begin
      for (int l = 0; l < N; l++)
        if (loc_t'(l) == chg_to && seize_q[l]) is_seize = 1'b1;
      for (int l = 0; l < N; l++) begin
        if (act_q == loc_t'(l) && chg_to != loc_t'(l)) begin
          if (is_seize) seized_d[l] = 1'b1;
          else          req_d[l]    = 1'b0;
        end
        if (chg_to == loc_t'(l)) begin
          req_d[l]   = 1'b0;
          seize_d[l] = 1'b0;
        end
      end
      act_d = chg_to;
      chg_d = (chg_to != NO_LOC);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0; seize_q <= '0; seized_q <= '0;
      act_q <= NO_LOC; nxt_q <= NO_LOC; pend_q <= 1'b0; chg_q <= 1'b0;
    end else begin
      req_q <= req_d; seize_q <= seize_d; seized_q <= seized_d;
      act_q <= act_d; nxt_q <= nxt_d; pend_q <= pend_d; chg_q <= chg_d;
    end
  end

  assign req_o     = req_q;
  assign seized_o  = seized_q;
  assign active_o  = act_q;
  assign changed_o = chg_q;
  assign pend_o    = pend_q;

  assert_abort_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !abort_done_i |=> pend_q);
  assert_one_seize_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(seize_q));
  assert_chg_has_owner_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> act_q != NO_LOC);
  assert_owner_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(act_q) < N) || (act_q == NO_LOC));
  assert_owner_no_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(act_q) < N) |-> !req_q[act_q]);
  assert_hold_owner_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !abort_done_i |=> $stable(act_q));
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int       N         = 5,
  parameter int       LOC_SHIFT = 12,
  parameter bit       EST_VAL   = 1'b1,
  localparam int      AW        = LOC_SHIFT + LOC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic          acc_we_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [7:0]    acc_wdata_i,
  input  logic          acc_hw_i,
  output logic [7:0]    acc_rdata_o,
  output logic [2:0]    active_o,
  output logic          loc_changed_o,
  output logic          abort_req_o,
  input  logic          abort_done_i
);
  loc_t loc, hi_req, act;
  logic reg_hit, loc_valid, any_req, wr, pend, chg;
  logic [N-1:0] req, seized, others;
  logic unused_wbits;

  assign unused_wbits = ^{acc_wdata_i[7:6], acc_wdata_i[2], acc_wdata_i[0]};

  loc_addr_decode #(.N(N), .LOC_SHIFT(LOC_SHIFT)) u_dec (
    .addr_i(acc_addr_i), .loc_o(loc), .reg_hit_o(reg_hit), .loc_valid_o(loc_valid));

  loc_prio_scan #(.N(N)) u_scan (
    .req_i(req), .hi_o(hi_req), .any_o(any_req), .others_o(others));

  // locality 4 is writable from hardware only
  assign wr = acc_valid_i && acc_we_i && reg_hit && loc_valid &&
              (loc != loc_t'(4) || acc_hw_i);

  loc_owner_fsm #(.N(N)) u_fsm (
    .clk_i, .rst_ni, .wr_i(wr), .loc_i(loc),
    .w_rel_i(acc_wdata_i[B_ACTIVE]), .w_seize_i(acc_wdata_i[B_SEIZE]),
    .w_req_i(acc_wdata_i[B_REQ]), .w_clr_seized_i(acc_wdata_i[B_SEIZED]),
    .abort_done_i, .hi_req_i(hi_req), .any_req_i(any_req),
    .req_o(req), .seized_o(seized), .active_o(act), .changed_o(chg), .pend_o(pend));

  always_comb begin
    acc_rdata_o = 8'hFF;
    if (loc_valid) begin
      acc_rdata_o = 8'h00;
      if (reg_hit)
        for (int l = 0; l < N; l++)
          if (loc == loc_t'(l)) begin
            acc_rdata_o[B_VALID]  = 1'b1;
            acc_rdata_o[B_ACTIVE] = (act == loc);
            acc_rdata_o[B_SEIZED] = seized[l];
            acc_rdata_o[B_PEND]   = others[l];
            acc_rdata_o[B_REQ]    = req[l];
            acc_rdata_o[0]        = EST_VAL;
          end
    end
  end

  assign active_o      = act;
  assign loc_changed_o = chg;
  assign abort_req_o   = pend;

  assert_hw_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_we_i && loc == loc_t'(4) && !acc_hw_i && !abort_done_i
    |=> $stable(active_o) && $stable(abort_req_o));
  assert_hi_win_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_we_i && !loc_valid && !abort_done_i
    |=> $stable(active_o) && $stable(abort_req_o));
endmodule

// File: tb/tb_loc_arbiter.sv
`timescale 1ns/1ps
module tb_loc_arbiter;
  logic clk = 0, rst_n = 0;
  logic valid = 0, we = 0, hw = 0, done = 0;
  logic [14:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] active;
  logic chg, abrt;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  loc_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_we_i(we),
    .acc_addr_i(addr), .acc_wdata_i(wdata), .acc_hw_i(hw),
    .acc_rdata_o(rdata), .active_o(active), .loc_changed_o(chg),
    .abort_req_o(abrt), .abort_done_i(done));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; valid = 0; done = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input int loc, input logic [7:0] d, input logic h = 1'b1);
    @(negedge clk);
    addr = {loc[2:0], 12'h000}; wdata = d; we = 1; valid = 1; hw = h;
    @(negedge clk);
    valid = 0; we = 0; hw = 0;
  endtask

  task automatic rd(input int loc, input int off, output logic [7:0] d);
    addr = {loc[2:0], off[11:0]};
    #1 d = rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
  endtask

  // expected ownership byte from R2 layout, EST_VAL = 1
  function automatic int exp_b(bit own, bit sz, bit pend, bit rq);
    return 8'h81 | (own << 5) | (sz << 4) | (pend << 2) | (rq << 1);
  endfunction

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R2 reset state
    for (int l = 0; l < 5; l++) begin rd(l, 0, d); chk("R2 reset byte", d, 8'h81); end
    chk("R2 reset owner", active, 7);
    chk("R2 reset abort", abrt, 0);
    // R1 decode
    rd(2, 4, d);  chk("R1 other offset", d, 8'h00);
    rd(6, 0, d);  chk("R1 window 6", d, 8'hFF);
    wr(6, 8'h02); chk("R1 write window 6", active, 7);
    // R3 / R6 per locality
    for (int a = 0; a < 5; a++) begin
      do_reset();
      wr(a, 8'h02);
      chk("R3 owner", active, a);
      chk("R3 pulse", chg, 1);
      @(negedge clk); chk("R3 pulse one cycle", chg, 0);
      rd(a, 0, d); chk("R3 owner byte", d, exp_b(1, 0, 0, 0));
      wr(a, 8'h20);
      chk("R6 unowned", active, 7);
      chk("R6 no pulse", chg, 0);
      chk("R6 no abort", abrt, 0);
    end
    // R4 R7 R5 over all pairs
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++) if (a != b) begin
        do_reset();
        wr(a, 8'h02);
        wr(b, 8'h02);
        rd(b, 0, d); chk("R4 requester byte", d, exp_b(0, 0, 0, 1));
        rd(a, 0, d); chk("R4 owner sees pending", d, exp_b(1, 0, 1, 0));
        wr(b, 8'h20);
        rd(b, 0, d); chk("R7 request withdrawn", d, exp_b(0, 0, 0, 0));
        chk("R7 owner kept", active, a);
        wr(b, 8'h02);
        wr(a, 8'h20);
        chk("R5 abort raised", abrt, 1);
        chk("R5 owner held", active, a);
        pulse_done();
        chk("R5 new owner", active, b);
        chk("R5 pulse", chg, 1);
        chk("R5 abort dropped", abrt, 0);
        rd(a, 0, d); chk("R5 old owner byte", d, exp_b(0, 0, 0, 0));
        rd(b, 0, d); chk("R5 new owner byte", d, exp_b(1, 0, 0, 0));
      end
    // R5 highest requester wins
    do_reset();
    wr(0, 8'h02); wr(1, 8'h02); wr(3, 8'h02); wr(2, 8'h02);
    wr(0, 8'h20); pulse_done();
    chk("R5 highest requester", active, 3);
    rd(1, 0, d); chk("R5 loser keeps request", d, exp_b(0, 0, 1, 1));
    // R8 R9 R10 seize over all pairs, extra bits must be ignored
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++) if (a != b) begin
        do_reset();
        wr(a, 8'h02);
        wr(b, 8'h2A);
        if (b > a) begin
          chk("R8 seize abort", abrt, 1);
          chk("R8 owner held", active, a);
          pulse_done();
          chk("R8 seizer owns", active, b);
          rd(a, 0, d); chk("R8 seized flag", d, exp_b(0, 1, 0, 0));
          rd(b, 0, d); chk("R8 seizer byte", d, exp_b(1, 0, 0, 0));
          wr(a, 8'h10);
          rd(a, 0, d); chk("R10 seized cleared", d, exp_b(0, 0, 0, 0));
        end else begin
          chk("R9 no abort", abrt, 0);
          chk("R9 owner kept", active, a);
          rd(b, 0, d); chk("R9 lower seizer byte", d, exp_b(0, 0, 0, 0));
        end
      end
    // R8 seize with no owner
    do_reset();
    wr(2, 8'h08); chk("R8 idle seize abort", abrt, 1);
    pulse_done(); chk("R8 idle seize owner", active, 2);
    rd(2, 0, d); chk("R8 idle seize byte", d, exp_b(1, 0, 0, 0));
    // R11 hardware-only locality 4
    do_reset();
    wr(4, 8'h02, 1'b0); chk("R11 dropped", active, 7);
    rd(4, 0, d); chk("R11 read allowed", d, 8'h81);
    wr(4, 8'h02, 1'b1); chk("R11 hw accepted", active, 4);
    // R12 R13 writes held off during abort
    do_reset();
    wr(1, 8'h02);
    wr(3, 8'h08);
    wr(4, 8'h08); wr(1, 8'h20); wr(0, 8'h02);
    repeat (3) @(negedge clk);
    chk("R13 abort held", abrt, 1);
    chk("R12 owner held", active, 1);
    pulse_done();
    chk("R12 first seizer owns", active, 3);
    rd(1, 0, d); chk("R12 old owner byte", d, exp_b(0, 1, 1, 0));
    rd(0, 0, d); chk("R12 request recorded", d, exp_b(0, 0, 0, 1));
    rd(4, 0, d); chk("R12 later seize ignored", d, exp_b(0, 0, 1, 0));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule